// File: doc/BRIEF.md
# Time-Sliced Domain Issue Gate

This block sits in front of a DRAM command scheduler and decides, on every controller cycle, which security domain is allowed to start a memory command. Time is cut into turns of a fixed number of cycles. Each turn belongs to exactly one domain, and ownership passes from domain to domain in round-robin order. The schedule runs on its own clock and does not react to demand. A domain keeps its turn even when it has nothing to send, and a busy domain never gets extra time.

The last part of every turn is a dead window in which no domain may start anything. This keeps an operation started by the owner from reaching into the next owner's turn. Two dead-window lengths are provided: a long one for shared banks and a short one for a bank-partitioned arrangement. The choice is taken from a mode input while reset is held, and it stays fixed until the next reset. A separate output tells the command builder to attach auto-precharge to every column read and write, so every row is closed when ownership changes hands.

Top module: `tpg_issue_gate`

## Requirements
- R1: While `rst` is high, every bit of `issue_en` is 0 and `owner_id` is 0. The first cycle after reset is cycle 0 of domain 0's turn.
- R2: At most one bit of `issue_en` is high in any cycle, and that bit is the one indexed by `owner_id`.
- R3: `owner_id` holds its value for exactly `TURN_LEN` cycles and then advances by one. It wraps from `NUM_DOM`-1 back to 0.
- R4: The turn schedule does not depend on `req_valid`. Ownership rotates at the same cycles when no domain is requesting.
- R5: In shared mode (`bank_part_mode`=0 at reset), the owner's `issue_en` bit equals its `req_valid` bit during the first `TURN_LEN`-`DEAD_LEN` cycles of the turn, and is 0 for the remaining `DEAD_LEN` cycles.
- R6: In partitioned mode (`bank_part_mode`=1 at reset), the dead window lasts `DEAD_LEN_PART` cycles. `bank_part_mode` is sampled only while `rst` is high, so changing it after reset has no effect.
- R7: Outside reset, `force_autopre` is 1 on every cycle.
- R8: The default parameters give 4 domains, a 256-cycle turn, a 172-cycle shared dead window and a 32-cycle partitioned dead window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_part_mode | input | 1 | Selects the short dead window when 1; sampled only while `rst` is high |
| req_valid | input | NUM_DOM | One bit per domain: the domain has a command ready |
| issue_en | output | NUM_DOM | One bit per domain: the domain may start a command this cycle |
| owner_id | output | $clog2(NUM_DOM) | Domain that owns the current turn |
| force_autopre | output | 1 | Attach auto-precharge to every column command |

## Verification
The bench targets the edges of the open window, the wrap of ownership from the last domain back to domain 0, and the first cycle after reset. An off-by-one window compare would grant or withhold exactly one cycle at the dead boundary. An off-by-one turn counter would move the owner one cycle early or late. A missing wrap would make the owner ID run past the last domain. The bench also holds every request low for whole turns, to catch a design that skips an idle domain. It toggles the mode input after reset, to catch a design that re-reads the mode while running. Each of these shows up as a mismatch in `issue_en` or `owner_id` at a cycle the bench computes from the turn arithmetic alone.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic {
        DEAD_SHARED  = 1'b0,
        DEAD_BANKPRT = 1'b1
    } dead_mode_e;

    function automatic int open_cycles(input int turn_len, input int dead_len);
        return turn_len - dead_len;
    endfunction

    function automatic int id_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tpg_turn_timer.sv
module tpg_turn_timer #(
    parameter int TURN_LEN = 256,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] slot,
    output logic             last_slot
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TURN_LEN - 1);

    assign last_slot = (slot == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (last_slot)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end
endmodule

// File: rtl/tpg_owner_ring.sv
module tpg_owner_ring #(
    parameter int NUM_DOM = 4,
    parameter int ID_W    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    output logic [ID_W-1:0] owner
);
    localparam logic [ID_W-1:0] TOP_ID = ID_W'(NUM_DOM - 1);

    always_ff @(posedge clk) begin
        if (rst)
            owner <= '0;
        else if (advance)
            owner <= (owner == TOP_ID) ? '0 : owner + 1'b1;
    end
endmodule

// File: rtl/tpg_window.sv
module tpg_window
    import tpg_pkg::*;
#(
    parameter int TURN_LEN      = 256,
    parameter int DEAD_LEN      = 172,
    parameter int DEAD_LEN_PART = 32,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_in,
    input  logic [CNT_W-1:0] slot,
    output logic             open
);
    localparam logic [CNT_W-1:0] LIM_SHARED = CNT_W'(open_cycles(TURN_LEN, DEAD_LEN));
    localparam logic [CNT_W-1:0] LIM_BANK   = CNT_W'(open_cycles(TURN_LEN, DEAD_LEN_PART));

    dead_mode_e       mode_q;
    logic [CNT_W-1:0] limit;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= mode_in ? DEAD_BANKPRT : DEAD_SHARED;
    end

    always_comb begin
        unique case (mode_q)
            DEAD_BANKPRT: limit = LIM_BANK;
            default:      limit = LIM_SHARED;
        endcase
    end

    assign open = (slot < limit);
endmodule

// File: rtl/tpg_issue_gate.sv
module tpg_issue_gate
    import tpg_pkg::*;
#(
    parameter int NUM_DOM       = 4,
    parameter int TURN_LEN      = 256,
    parameter int DEAD_LEN      = 172,
    parameter int DEAD_LEN_PART = 32,
    parameter int ID_W          = id_width(NUM_DOM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bank_part_mode,
    input  logic [NUM_DOM-1:0] req_valid,
    output logic [NUM_DOM-1:0] issue_en,
    output logic [ID_W-1:0]    owner_id,
    output logic               force_autopre
);
    localparam int CNT_W = $clog2(TURN_LEN);

    logic [CNT_W-1:0] slot;
    logic             last_slot;
    logic             open;

    tpg_turn_timer #(.TURN_LEN(TURN_LEN), .CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .last_slot (last_slot)
    );

    tpg_owner_ring #(.NUM_DOM(NUM_DOM), .ID_W(ID_W)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .advance (last_slot),
        .owner   (owner_id)
    );

    tpg_window #(
        .TURN_LEN      (TURN_LEN),
        .DEAD_LEN      (DEAD_LEN),
        .DEAD_LEN_PART (DEAD_LEN_PART),
        .CNT_W         (CNT_W)
    ) u_window (
        .clk     (clk),
        .rst     (rst),
        .mode_in (bank_part_mode),
        .slot    (slot),
        .open    (open)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign issue_en[d] = !rst && open && req_valid[d] && (owner_id == ID_W'(d));
    end

    assign force_autopre = 1'b1;
endmodule

// File: rtl/tpg_issue_gate_chk.sv
module tpg_issue_gate_chk #(
    parameter int NUM_DOM       = 4,
    parameter int TURN_LEN      = 256,
    parameter int DEAD_LEN      = 172,
    parameter int DEAD_LEN_PART = 32,
    parameter int ID_W          = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               bank_part_mode,
    input logic [NUM_DOM-1:0] req_valid,
    input logic [NUM_DOM-1:0] issue_en,
    input logic [ID_W-1:0]    owner_id,
    input logic               force_autopre
);
    int unsigned age;
    logic        short_dead;
    int unsigned open_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            age        <= 0;
            short_dead <= bank_part_mode;
        end else begin
            age <= (age == TURN_LEN - 1) ? 0 : age + 1;
        end
    end

    assign open_len = short_dead ? (TURN_LEN - DEAD_LEN_PART) : (TURN_LEN - DEAD_LEN);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (issue_en == '0)); // R1

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_en)); // R2

    AST_OWNER_ONLY: assert property (@(posedge clk) disable iff (rst)
        (issue_en != '0) |-> issue_en[owner_id]); // R2

    AST_OWNER_STEP: assert property (@(posedge clk) disable iff (rst)
        (owner_id != $past(owner_id)) |->
            (owner_id == (($past(owner_id) == ID_W'(NUM_DOM - 1)) ? '0 : $past(owner_id) + 1'b1))); // R3

    AST_TURN_TIMING: assert property (@(posedge clk) disable iff (rst)
        (age == 0 && !$past(rst)) |-> (owner_id != $past(owner_id))); // R4

    AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (age >= open_len) |-> (issue_en == '0)); // R5

    AST_OPEN_GRANT: assert property (@(posedge clk) disable iff (rst)
        (age < open_len && req_valid[owner_id]) |-> issue_en[owner_id]); // R6

    AST_AUTOPRE: assert property (@(posedge clk) disable iff (rst)
        force_autopre); // R7
endmodule

bind tpg_issue_gate tpg_issue_gate_chk #(
    .NUM_DOM       (NUM_DOM),
    .TURN_LEN      (TURN_LEN),
    .DEAD_LEN      (DEAD_LEN),
    .DEAD_LEN_PART (DEAD_LEN_PART),
    .ID_W          (ID_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bank_part_mode (bank_part_mode),
    .req_valid      (req_valid),
    .issue_en       (issue_en),
    .owner_id       (owner_id),
    .force_autopre  (force_autopre)
);

// File: tb/tpg_issue_gate_test.sv
module tpg_issue_gate_test;
    localparam int N  = 3;
    localparam int T  = 12;
    localparam int D  = 7;
    localparam int DP = 2;
    localparam int NB = 4;
    localparam int TB = 256;
    localparam int DB = 172;
    localparam int DPB = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] issue_en;
    logic [1:0]   owner_id;
    logic         force_autopre;
    logic [NB-1:0] issue_b;
    logic [1:0]    owner_b;
    logic          fap_b;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tpg_issue_gate #(.NUM_DOM(N), .TURN_LEN(T), .DEAD_LEN(D), .DEAD_LEN_PART(DP)) uut (
        .clk(clk), .rst(rst), .bank_part_mode(mode), .req_valid(req),
        .issue_en(issue_en), .owner_id(owner_id), .force_autopre(force_autopre)
    );

    tpg_issue_gate uut_dflt (
        .clk(clk), .rst(rst), .bank_part_mode(mode), .req_valid(4'hF),
        .issue_en(issue_b), .owner_id(owner_b), .force_autopre(fap_b)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 60000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // kind: 0 all request, 1 none, 2 pseudo-random, 3 all request with mode toggling
    task automatic run_phase(input bit m, input int kind, input int ncyc);
        bit          short_dead;
        int          lim, limb;
        @(negedge clk);
        rst  = 1'b1;
        mode = m;
        req  = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 issue_en during reset", int'(issue_en), 0);
        check("R1 owner during reset", int'(owner_id), 0);
        check("R1 default instance quiet in reset", int'(issue_b), 0);
        short_dead = m;
        lim  = short_dead ? T - DP : T - D;
        limb = short_dead ? TB - DPB : TB - DB;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            int slot, own, exp_issue, slotb, ownb, exp_b;
            string tg;
            if (k > 0) @(negedge clk);
            case (kind)
                0: req = '1;
                1: req = '0;
                2: req = N'((k * 5 + 3) ^ (k >> 2));
                default: begin req = '1; mode = k[0]; end
            endcase
            #1;
            slot = k % T;
            own  = (k / T) % N;
            exp_issue = (slot < lim && req[own]) ? (1 << own) : 0;
            tg = short_dead ? "R6 issue window (partitioned)" : "R5 issue window (shared)";
            check(tg, int'(issue_en), exp_issue);
            check(kind == 1 ? "R4 owner rotates with no requests" : "R3 owner rotation",
                  int'(owner_id), own);
            check("R2 at most one grant", ($countones(issue_en) <= 1) ? 1 : 0, 1);
            check("R7 auto-precharge forced", int'(force_autopre), 1);
            slotb = k % TB;
            ownb  = (k / TB) % NB;
            exp_b = (slotb < limb) ? (1 << ownb) : 0;
            check("R8 default issue window", int'(issue_b), exp_b);
            check("R8 default owner", int'(owner_b), ownb);
        end
    endtask

    initial begin
        run_phase(1'b0, 0, 4 * T + 3);
        run_phase(1'b0, 1, 4 * T + 3);
        run_phase(1'b0, 2, 5 * T);
        run_phase(1'b1, 3, 4 * T + 3);
        run_phase(1'b1, 2, 4 * T);
        run_phase(1'b0, 0, 5 * TB + 2);
        run_phase(1'b1, 3, 4 * TB + 2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule